// File: doc/BRIEF.md
# Six-Output Motor PWM Timer

This block drives six PWM outputs for a three-phase motor bridge. One free-running counter produces edge-aligned periods, and each output compares that count with its own duty value. The counter advances on every system clock or on each rising edge of an external pulse input. A prescaler can slow it by 2, 4 or 8. At the end of every 1st, 2nd, 4th or 8th period, the block raises a reload strobe for one cycle.

Software programs the block through a plain write/read register port. The settings that shape timing are staged in holding registers and only take effect at fixed boundaries. The reload-rate field takes effect at the next period end. The prescaler, the period and the six duty values take effect at the next reload. Reads always return the staged values. The pairing mode and the per-pair polarity take effect as soon as they are written. The six outputs can run as three complementary pairs or as six separate channels.

Top module: `mpwm_timer`

## Requirements
- R1: After reset, every register reads zero. With period 0 and all duties at 0, the outputs equal 6'b101010 and `reload_stb` is high in every cycle.
- R2: The counter steps from 0 up to the active period value P, one step per count tick, and then wraps to 0. A period therefore lasts P+1 ticks. Each output is high while the count is below its active duty value.
- R3: Control bits [7:6] select the reload rate. Encodings 0, 1, 2 and 3 raise `reload_stb` once every 1, 2, 4 or 8 periods. The strobe is high during the final count of the period that ends the group.
- R4: A newly written reload rate takes effect at the next period end, not at a reload.
- R5: Control bits [5:4] divide the count tick by 1, 2, 4 or 8, for encodings 0 to 3.
- R6: A newly written prescaler value takes effect only at the next reload, not at an earlier period end.
- R7: Register map: address 0 is control, addresses 1 to 6 hold the duty values of outputs 0 to 5, and address 7 holds the period. A read returns the staged value in the same cycle, including values not yet in effect.
- R8: With control bit 3 at 0, output 2k+1 is the inverse of output 2k for each pair k = 0, 1, 2. Both outputs of pair k then use the duty value of output 2k.
- R9: With control bit 3 at 1, each output compares the count with its own duty value.
- R10: Control bit k (k = 0, 1, 2) inverts both outputs of pair k. The pairing bit and the polarity bits take effect in the cycle after the write.
- R11: With `clk_sel` high, the counter ticks once for each rising edge of `ext_clk_in`. A rising edge is seen two clock cycles after it is sampled.
- R12: Written duty and period values take effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 0: count on system clock, 1: count on external pulse edges |
| ext_clk_in | input | 1 | External count pulse input (asynchronous) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Staged value of the addressed register |
| pwm_out | output | 6 | PWM outputs; pair k is outputs 2k and 2k+1 |
| reload_stb | output | 1 | One-cycle reload event strobe |

## Verification
A write is captured at the next clock edge. Read data and a polarity or pairing change appear in the cycle after that edge. The outputs and `reload_stb` are decoded from registered state, so they are valid in the same cycle as the count. Buffered fields are checked by measuring, in cycles, the spacing between consecutive `reload_stb` pulses, or by checking an output just before and just after a reload. Inputs are driven 1 ns after the falling edge, and every port is compared at the falling edge against a cycle model in the bench.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int PAIRS  = 3;
  localparam int RATE_W = 2;
  localparam int PS_W   = 2;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [PS_W-1:0]   presc;
    logic              indep;
    logic [PAIRS-1:0]  pol;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/mpwm_tick_gen.sv
module mpwm_tick_gen #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_ext,
  input  logic            ext_in,
  input  logic [PS_W-1:0] ps_act,
  output logic            cnt_tick
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [2:0]       sync_q;
  logic [PRE_W-1:0] pre_q;
  logic             ext_rise;
  logic             raw_tick;
  logic [PRE_W-1:0] pre_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_in};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign raw_tick = sel_ext ? ext_rise : 1'b1;
  assign pre_lim  = PRE_W'((1 << ps_act) - 1);
  assign cnt_tick = raw_tick && (pre_q >= pre_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (raw_tick) pre_q <= cnt_tick ? '0 : pre_q + 1'b1;
  end

  // R11: an external edge never yields two ticks in a row
  p_ext_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && cnt_tick) |=> (!sel_ext || !cnt_tick));

  // R5: a divided tick is never followed at once by another one
  p_div_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_act != '0 && cnt_tick) |=> (!cnt_tick || ps_act != $past(ps_act)));
endmodule

// File: rtl/mpwm_period_ctr.sv
module mpwm_period_ctr #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic [CNT_W-1:0]  per_act,
  input  logic [RATE_W-1:0] rate_st,
  output logic [CNT_W-1:0]  cnt,
  output logic              period_end,
  output logic              reload_ev
);
  localparam int END_W = (1 << RATE_W) - 1;

  logic [RATE_W-1:0] rate_act;
  logic [END_W-1:0]  end_q;
  logic [END_W-1:0]  end_lim;

  assign end_lim    = END_W'((1 << rate_act) - 1);
  assign period_end = cnt_tick && (cnt == per_act);
  assign reload_ev  = period_end && (end_q >= end_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt_tick) cnt <= period_end ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_act <= '0;
      end_q    <= '0;
    end else if (period_end) begin
      rate_act <= rate_st;
      end_q    <= reload_ev ? '0 : end_q + 1'b1;
    end
  end

  // R2: the count never passes the active period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  // R2: a period end wraps the count
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0));

  // R4: the reload rate only moves at a period end
  p_rate_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_act) |-> $past(period_end));
endmodule

// File: rtl/mpwm_out_stage.sv
module mpwm_out_stage #(
  parameter int CNT_W   = 8,
  parameter int N_PAIRS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [2*N_PAIRS-1:0][CNT_W-1:0] duty,
  input  logic                            indep,
  input  logic [N_PAIRS-1:0]              pol,
  output logic [2*N_PAIRS-1:0]            pwm
);
  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    logic even_raw;
    logic odd_raw;
    assign even_raw     = cnt < duty[2*k];
    assign odd_raw      = indep ? (cnt < duty[2*k+1]) : ~even_raw;
    assign pwm[2*k]     = even_raw ^ pol[k];
    assign pwm[2*k+1]   = odd_raw ^ pol[k];

    // R8: complementary pair outputs always differ
    p_comp_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !indep |-> (pwm[2*k+1] != pwm[2*k]));
  end
endmodule

// File: rtl/mpwm_timer.sv
module mpwm_timer
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_sel,
  input  logic                 ext_clk_in,
  input  logic                 reg_wr_en,
  input  logic [2:0]           reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic [2*PAIRS-1:0]   pwm_out,
  output logic                 reload_stb
);
  localparam int N_CH     = 2 * PAIRS;
  localparam int AW       = 3;
  localparam int PER_ADDR = N_CH + 1;

  ctl_t                        ctl_st;
  logic [N_CH-1:0][CNT_W-1:0]  duty_st, duty_act;
  logic [CNT_W-1:0]            per_st, per_act;
  logic [PS_W-1:0]             ps_act;
  logic                        cnt_tick;
  logic [CNT_W-1:0]            cnt;
  logic                        period_end;
  logic                        reload_ev;

  // staging registers written by the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_st  <= '0;
      duty_st <= '0;
      per_st  <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == AW'(0))        ctl_st <= ctl_t'(reg_wdata[CTL_W-1:0]);
      if (reg_addr == AW'(PER_ADDR)) per_st <= reg_wdata;
      for (int c = 0; c < N_CH; c++)
        if (reg_addr == AW'(c + 1)) duty_st[c] <= reg_wdata;
    end
  end

  // commit at the reload event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_act   <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (reload_ev) begin
      ps_act   <= ctl_st.presc;
      per_act  <= per_st;
      duty_act <= duty_st;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0))        reg_rdata = CNT_W'(ctl_st);
    if (reg_addr == AW'(PER_ADDR)) reg_rdata = per_st;
    for (int c = 0; c < N_CH; c++)
      if (reg_addr == AW'(c + 1)) reg_rdata = duty_st[c];
  end

  mpwm_tick_gen #(.PS_W(PS_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_ext  (clk_sel),
    .ext_in   (ext_clk_in),
    .ps_act   (ps_act),
    .cnt_tick (cnt_tick)
  );

  mpwm_period_ctr #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .per_act    (per_act),
    .rate_st    (ctl_st.rate),
    .cnt        (cnt),
    .period_end (period_end),
    .reload_ev  (reload_ev)
  );

  mpwm_out_stage #(.CNT_W(CNT_W), .N_PAIRS(PAIRS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .duty  (duty_act),
    .indep (ctl_st.indep),
    .pol   (ctl_st.pol),
    .pwm   (pwm_out)
  );

  assign reload_stb = reload_ev;

  // R6: the prescaler only moves at a reload
  p_presc_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ps_act) |-> $past(reload_ev));

  // R12: duty values only move at a reload
  p_duty_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_act) |-> $past(reload_ev));

  // R12: the period only moves at a reload
  p_period_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_act) |-> $past(reload_ev));

  // R3: a reload strobe only ends a period
  p_reload_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |=> (cnt == '0 || !$past(cnt_tick)));
endmodule

// File: tb/test_mpwm_timer.sv
module test_mpwm_timer;
  localparam int CW = 8;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_sel = 1'b0;
  logic          ext_clk_in = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic [NC-1:0] pwm_out;
  logic          reload_stb;

  always #2 clk = ~clk;

  mpwm_timer i_mpwm_timer (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk_in(ext_clk_in),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .reload_stb(reload_stb)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int ext_mode = 0;
  int ext_ph = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // external pulse source
  always @(negedge clk) begin
    #1;
    case (ext_mode)
      1: begin
        ext_clk_in <= (ext_ph < 2);
        ext_ph <= (ext_ph == 4) ? 0 : ext_ph + 1;
      end
      2: ext_clk_in <= 1'($urandom_range(0, 1));
      default: ext_clk_in <= 1'b0;
    endcase
  end

  // ---------------- cycle model built from the requirements
  logic [2:0]             m_sync, m_pre, m_endc;
  logic [CW-1:0]          m_cnt, m_per_act, m_per_st;
  logic [1:0]             m_rate_act, m_ps_act;
  logic [NC-1:0][CW-1:0]  m_duty_act, m_duty_st;
  logic [7:0]             m_ctl;
  logic                   m_raw, m_tick, m_pend, m_rel;

  always_comb begin
    m_raw  = clk_sel ? (m_sync[1] & ~m_sync[2]) : 1'b1;
    m_tick = m_raw && (int'(m_pre) >= (1 << m_ps_act) - 1);
    m_pend = m_tick && (m_cnt == m_per_act);
    m_rel  = m_pend && (int'(m_endc) >= (1 << m_rate_act) - 1);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '0; m_pre <= '0; m_endc <= '0; m_cnt <= '0;
      m_per_act <= '0; m_per_st <= '0; m_rate_act <= '0; m_ps_act <= '0;
      m_duty_act <= '0; m_duty_st <= '0; m_ctl <= '0;
    end else begin
      m_sync <= {m_sync[1:0], ext_clk_in};
      if (m_raw)  m_pre <= m_tick ? 3'd0 : m_pre + 3'd1;
      if (m_tick) m_cnt <= m_pend ? '0 : m_cnt + 1'b1;
      if (m_pend) begin
        m_rate_act <= m_ctl[7:6];
        m_endc <= m_rel ? 3'd0 : m_endc + 3'd1;
      end
      if (m_rel) begin
        m_ps_act <= m_ctl[5:4];
        m_per_act <= m_per_st;
        m_duty_act <= m_duty_st;
      end
      if (reg_wr_en) begin
        if (reg_addr == 3'd0) m_ctl <= reg_wdata;
        else if (reg_addr == 3'd7) m_per_st <= reg_wdata;
        else m_duty_st[reg_addr - 3'd1] <= reg_wdata;
      end
    end
  end

  function automatic logic [NC-1:0] f_pwm(input logic [CW-1:0] c,
      input logic [NC-1:0][CW-1:0] d, input logic ind, input logic [2:0] pol);
    logic [NC-1:0] r;
    for (int k = 0; k < 3; k++) begin
      logic e, o;
      e = c < d[2*k];
      o = ind ? (c < d[2*k+1]) : !e;
      r[2*k] = e ^ pol[k];
      r[2*k+1] = o ^ pol[k];
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] f_read(input logic [2:0] a);
    if (a == 3'd0) return m_ctl;
    if (a == 3'd7) return m_per_st;
    return m_duty_st[a - 3'd1];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R12 outputs vs model", 32'(pwm_out),
          32'(f_pwm(m_cnt, m_duty_act, m_ctl[3], m_ctl[2:0])));
      chk("R3 R4 strobe vs model", 32'(reload_stb), 32'(m_rel));
      chk("R7 readback vs model", 32'(reg_rdata), 32'(f_read(reg_addr)));
    end
  end

  // ---------------- stimulus helpers
  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_stb(output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!reload_stb && n < 3000);
    if (n >= 3000) chk("R3 strobe timeout", 32'(n), 32'd0);
    t = cyc;
  endtask

  task automatic settle(input int n);
    int t;
    for (int i = 0; i < n; i++) wait_stb(t);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int t0, t1, t2, hi0, hi1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", 32'(pwm_out), 32'h2A);
    chk("R1 reset strobe", 32'(reload_stb), 32'd1);
    chk("R1 reset control read", 32'(reg_rdata), 32'd0);

    // R7 readback of staged value before it takes effect
    wr(3'd7, 8'd3);
    wr(3'd0, 8'hC0);
    reg_addr = 3'd0;
    @(negedge clk);
    chk("R7 staged control read", 32'(reg_rdata), 32'hC0);

    // R3 all reload-rate encodings, period of 4 ticks
    for (int r = 0; r < 4; r++) begin
      wr(3'd0, 8'(r << 6));
      settle(2);
      wait_stb(t0); wait_stb(t1);
      chk("R3 reload spacing", 32'(t1 - t0), 32'(4 << r));
    end

    // R4 rate 3 -> 0 commits at next period end
    wait_stb(t0);
    wr(3'd0, 8'h00);
    wait_stb(t1);
    chk("R4 first spacing after rate change", 32'(t1 - t0), 32'd8);
    wait_stb(t2);
    chk("R4 second spacing after rate change", 32'(t2 - t1), 32'd4);

    // R6 / R5 prescaler commits at reload only
    wr(3'd0, 8'hC0);
    settle(2);
    wait_stb(t0);
    wr(3'd0, 8'hD0);
    wait_stb(t1);
    chk("R6 spacing before prescaler commit", 32'(t1 - t0), 32'd32);
    wait_stb(t2);
    chk("R5 divide-by-2 spacing", 32'(t2 - t1), 32'd64);
    wr(3'd0, 8'h30);
    settle(3);
    wait_stb(t0); wait_stb(t1);
    chk("R5 divide-by-8 spacing", 32'(t1 - t0), 32'd32);

    // R12 duty commit waits for reload
    wr(3'd0, 8'hC0);
    settle(3);
    wait_stb(t0);
    wr(3'd1, 8'd4);
    repeat (4) @(negedge clk);
    chk("R12 duty not yet in effect", 32'(pwm_out[0]), 32'd0);
    wait_stb(t1);
    @(negedge clk);
    chk("R12 duty in effect after reload", 32'(pwm_out[0]), 32'd1);

    // R8 complementary pairs, R10 polarity
    wr(3'd0, 8'h00);
    wr(3'd3, 8'd0);
    wr(3'd5, 8'd4);
    settle(3);
    @(negedge clk);
    chk("R8 complementary pattern", 32'(pwm_out), 32'b011001);
    wr(3'd0, 8'h02);
    @(negedge clk);
    chk("R10 pair 1 inverted", 32'(pwm_out), 32'b010101);

    // R9 independent channels
    wr(3'd2, 8'd4);
    wr(3'd4, 8'd4);
    wr(3'd6, 8'd4);
    wr(3'd0, 8'h08);
    settle(3);
    @(negedge clk);
    chk("R9 independent pattern", 32'(pwm_out), 32'b111011);
    wr(3'd0, 8'h0D);
    @(negedge clk);
    chk("R10 pairs 0 and 2 inverted", 32'(pwm_out), 32'b001000);

    // R2 period length and duty width
    wr(3'd0, 8'h00);
    wr(3'd7, 8'd5);
    wr(3'd1, 8'd2);
    settle(3);
    wait_stb(t0); wait_stb(t1);
    chk("R2 period of six ticks", 32'(t1 - t0), 32'd6);
    hi0 = 0; hi1 = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hi0 += int'(pwm_out[0]);
      hi1 += int'(pwm_out[1]);
    end
    chk("R2 high count of output 0", 32'(hi0), 32'd2);
    chk("R8 high count of output 1", 32'(hi1), 32'd4);

    // R11 external pulses every 5 cycles, period of 4 ticks
    wr(3'd7, 8'd3);
    #1 clk_sel = 1'b1;
    ext_mode = 1;
    settle(3);
    wait_stb(t0); wait_stb(t1);
    chk("R11 external clock spacing", 32'(t1 - t0), 32'd20);

    // random phase checked against the model every cycle
    ext_mode = 2;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      #1;
      if ($urandom_range(0, 5) == 0) begin
        reg_wr_en = 1'b1;
        reg_addr = 3'($urandom_range(0, 7));
        if (reg_addr == 3'd7)      reg_wdata = 8'($urandom_range(0, 9));
        else if (reg_addr == 3'd0) reg_wdata = 8'($urandom_range(0, 255));
        else                       reg_wdata = 8'($urandom_range(0, 11));
      end else begin
        reg_wr_en = 1'b0;
        reg_addr = 3'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 199) == 0) clk_sel = ~clk_sel;
    end
    reg_wr_en = 1'b0;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule